// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns the system clock into the timing strobes a serial port needs. A prescale counter counts up from zero to the divisor value n and then starts again, so it produces one oversample tick every n+1 clocks. A phase counter groups these ticks into bit periods and raises a bit tick on the last tick of each bit. The number of ticks per bit, and so the bit rate, is set by three mode pins: counter width, high-speed and synchronous. The divisor sits in two byte registers that software loads through a small write port.

The same tick stream also drives the receive sampler. In the slower asynchronous modes it takes three samples of the receive line around the middle of each bit and keeps the majority value. In the synchronous mode and the fastest asynchronous mode it takes one sample at the middle of the bit. The receive input must already be synchronised to the clock.

Top module: `baud_rate_gen`

## Requirements
- R1: With `wideMode`=0 the divisor n is the low byte only (write with `wrSel`=0). The high byte has no effect, and `osTick` is high for one cycle in every n+1 cycles.
- R2: With `wideMode`=1 the divisor n is {high byte, low byte}, where the high byte is written with `wrSel`=1. `osTick` has period n+1.
- R3: The ticks per bit F are set by the mode pins. With `syncMode`=0: F=64 for wide=0/fast=0, 16 for wide=0/fast=1, 16 for wide=1/fast=0, and 4 for wide=1/fast=1. With `syncMode`=1, F=4 whatever `fastMode` is. `bitTick` has period F·(n+1) and is high only together with `osTick`.
- R4: A write to either byte restarts both counters. If the write is presented in cycle 0, the first `osTick` comes in cycle n+1 and the first `bitTick` in cycle F·(n+1).
- R5: A divisor of zero does not lock the block up. `osTick` is then high in every cycle and `bitTick` in every F-th cycle.
- R6: After reset both divisor bytes are zero, `rxSample` is 1 and `rxValid` is 0.
- R7: When `syncMode`=0 and not both `wideMode` and `fastMode` are set, the sampler uses a vote. Let the ticks of a bit be numbered 0..F-1 and let m=F/2. The sampler reads `rxIn` on ticks m-1, m and m+1, and `rxSample` takes the majority of those three reads.
- R8: When `syncMode`=1, or when `wideMode` and `fastMode` are both set, the sampler reads `rxIn` once, on tick m, and `rxSample` takes that value. Other ticks have no effect on the result.
- R9: `rxValid` pulses high for exactly one cycle per bit, in the cycle after the tick that decided the bit. `rxSample` holds its value between decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Divisor write strobe |
| wrSel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wrData | input | 8 | Byte to write |
| wideMode | input | 1 | 1 selects the 16-bit divisor |
| fastMode | input | 1 | High-speed select (asynchronous only) |
| syncMode | input | 1 | 1 selects synchronous operation |
| rxIn | input | 1 | Synchronised receive line |
| osTick | output | 1 | Oversample tick |
| bitTick | output | 1 | Bit-period tick |
| rxSample | output | 1 | Decided receive bit |
| rxValid | output | 1 | One-cycle strobe for a new decision |

## Verification
The assertions assume that `rxIn` is already synchronous to `clk`. They also assume that the mode pins change only between bits or just before a divisor write, so the counters line up again with the new mode. The stimulus follows this: each mode change is followed at once by writes to both divisor bytes. Every receive pattern is lined up with the bit boundary that the bench sees on `bitTick`. Glitches are placed on numbered oversample ticks, so voting and single sampling give different answers from the same waveform.

// File: rtl/baud_rate_gen_pkg.sv
package baud_rate_gen_pkg;
  localparam int unsigned OS_SLOW = 64;
  localparam int unsigned OS_MID  = 16;
  localparam int unsigned OS_FAST = 4;
  localparam int unsigned PHASE_W = $clog2(OS_SLOW);
  localparam int unsigned FACT_W  = PHASE_W + 1;

  typedef struct packed {
    logic restart;
    logic shiftEn;
    logic decide;
    logic useVote;
  } dpCtrl_t;
endpackage

// File: rtl/baud_rate_ctrl.sv
module baud_rate_ctrl
  import baud_rate_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    wideMode,
  input  logic    fastMode,
  input  logic    syncMode,
  input  logic    baseTick,
  output dpCtrl_t dpCtrl,
  output logic    bitTick
);
  logic [FACT_W-1:0]  osFactor;
  logic [FACT_W-1:0]  midPoint;
  logic [FACT_W-1:0]  lastIdx;
  logic [FACT_W-1:0]  phaseExt;
  logic [PHASE_W-1:0] phase;
  logic               singleSel;
  logic               atLast;

  always_comb begin
    singleSel = syncMode | (wideMode & fastMode);
    if (syncMode)      osFactor = FACT_W'(OS_FAST);
    else if (wideMode) osFactor = fastMode ? FACT_W'(OS_FAST) : FACT_W'(OS_MID);
    else               osFactor = fastMode ? FACT_W'(OS_MID)  : FACT_W'(OS_SLOW);
    midPoint = osFactor >> 1;
    lastIdx  = osFactor - FACT_W'(1);
    phaseExt = {1'b0, phase};
    atLast   = phaseExt >= lastIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          phase <= '0;
    else if (wrEn)      phase <= '0;
    else if (baseTick)  phase <= atLast ? '0 : phase + PHASE_W'(1);
  end

  always_comb begin
    dpCtrl.restart = wrEn;
    dpCtrl.useVote = !singleSel;
    dpCtrl.shiftEn = baseTick && !singleSel &&
                     ((phaseExt == midPoint - FACT_W'(1)) || (phaseExt == midPoint));
    dpCtrl.decide  = baseTick &&
                     (singleSel ? (phaseExt == midPoint) : (phaseExt == midPoint + FACT_W'(1)));
    bitTick        = baseTick && atLast;
  end
endmodule

// File: rtl/baud_rate_dp.sv
module baud_rate_dp
  import baud_rate_gen_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wideMode,
  input  logic              rxIn,
  input  dpCtrl_t           dpCtrl,
  output logic              baseTick,
  output logic              rxSample,
  output logic              rxValid
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] divLo;
  logic [BYTE_W-1:0] divHi;
  logic [CNT_W-1:0]  divEff;
  logic [CNT_W-1:0]  preCnt;
  logic [1:0]        sampleHist;
  logic              voteBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLo <= '0;
      divHi <= '0;
    end else if (wrEn) begin
      if (wrSel) divHi <= wrData;
      else       divLo <= wrData;
    end
  end

  always_comb begin
    divEff   = wideMode ? {divHi, divLo} : {{BYTE_W{1'b0}}, divLo};
    baseTick = preCnt >= divEff;
    voteBit  = (sampleHist[1] & sampleHist[0]) | (sampleHist[1] & rxIn) |
               (sampleHist[0] & rxIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            preCnt <= '0;
    else if (dpCtrl.restart || baseTick)  preCnt <= '0;
    else                                  preCnt <= preCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleHist <= 2'b11;
      rxSample   <= 1'b1;
      rxValid    <= 1'b0;
    end else begin
      if (dpCtrl.shiftEn) sampleHist <= {sampleHist[0], rxIn};
      if (dpCtrl.decide)  rxSample   <= dpCtrl.useVote ? voteBit : rxIn;
      rxValid <= dpCtrl.decide;
    end
  end
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_rate_gen_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wideMode,
  input  logic              fastMode,
  input  logic              syncMode,
  input  logic              rxIn,
  output logic              osTick,
  output logic              bitTick,
  output logic              rxSample,
  output logic              rxValid
);
  dpCtrl_t dpCtrl;
  logic    baseTick;

  baud_rate_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wideMode (wideMode),
    .fastMode (fastMode),
    .syncMode (syncMode),
    .baseTick (baseTick),
    .dpCtrl   (dpCtrl),
    .bitTick  (bitTick)
  );

  baud_rate_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .wideMode (wideMode),
    .rxIn     (rxIn),
    .dpCtrl   (dpCtrl),
    .baseTick (baseTick),
    .rxSample (rxSample),
    .rxValid  (rxValid)
  );

  assign osTick = baseTick;
endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic wideMode,
  input logic fastMode,
  input logic syncMode,
  input logic rxIn,
  input logic osTick,
  input logic bitTick,
  input logic rxSample,
  input logic rxValid
);
  assert_bit_on_os_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> osTick);

  assert_restart_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !bitTick);

  assert_valid_after_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(osTick));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_single_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(syncMode || (wideMode && fastMode))) |-> (rxSample == $past(rxIn)));
endmodule

bind baud_rate_gen baud_rate_gen_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wideMode (wideMode),
  .fastMode (fastMode),
  .syncMode (syncMode),
  .rxIn     (rxIn),
  .osTick   (osTick),
  .bitTick  (bitTick),
  .rxSample (rxSample),
  .rxValid  (rxValid)
);

// File: tb/baud_rate_gen_tb_top.sv
module baud_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic wide; logic fast; logic sync;
    logic [7:0] lo; logic [7:0] hi;
    int expOs; int expBit;
  } vec_t;

  // R1 rows: 8-bit with junk high byte; R2 rows: 16-bit; R5 row: zero divisor
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 1'b0, 8'd3, 8'hFF, 4,   256 },
    '{1'b0, 1'b1, 1'b0, 8'd5, 8'hAA, 6,   96  },
    '{1'b1, 1'b0, 1'b0, 8'd2, 8'd1,  259, 4144},
    '{1'b1, 1'b1, 1'b0, 8'd7, 8'd0,  8,   32  },
    '{1'b0, 1'b0, 1'b1, 8'd9, 8'd3,  10,  40  },
    '{1'b0, 1'b1, 1'b1, 8'd9, 8'd3,  10,  40  },
    '{1'b1, 1'b0, 1'b1, 8'd4, 8'd1,  261, 1044},
    '{1'b1, 1'b1, 1'b1, 8'd0, 8'd2,  513, 2052},
    '{1'b0, 1'b0, 1'b0, 8'd0, 8'd7,  1,   64  }
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic wideMode = 1'b0, fastMode = 1'b0, syncMode = 1'b0;
  logic rxIn = 1'b1;
  logic osTick, bitTick, rxSample, rxValid;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  baud_rate_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wideMode(wideMode), .fastMode(fastMode), .syncMode(syncMode), .rxIn(rxIn),
    .osTick(osTick), .bitTick(bitTick), .rxSample(rxSample), .rxValid(rxValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setMode(input logic w, input logic f, input logic s);
    @(negedge clk);
    wideMode = w; fastMode = f; syncMode = s;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(output int osP, output int bitP);
    int t0;
    do @(negedge clk); while (!osTick);
    t0 = cyc;
    do @(negedge clk); while (!osTick);
    osP = cyc - t0;
    do @(negedge clk); while (!bitTick);
    t0 = cyc;
    do @(negedge clk); while (!bitTick);
    bitP = cyc - t0;
  endtask

  task automatic restartCheck(input logic sel, input logic [7:0] d);
    int k, firstOs, firstBit;
    setMode(1'b1, 1'b0, 1'b0);
    writeReg(1'b0, 8'd100);
    writeReg(1'b1, 8'd0);
    repeat (57) @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    k = 0; firstOs = -1; firstBit = -1;
    while (firstBit < 0 && k < 4000) begin
      @(negedge clk);
      wrEn = 1'b0;
      k++;
      if (osTick && firstOs < 0) firstOs = k;
      if (bitTick) firstBit = k;
    end
    check(firstOs == 101, "R4", "first osTick after write", firstOs, 101);
    check(firstBit == 1616, "R4", "first bitTick after write", firstBit, 1616);
  endtask

  task automatic bitCheck(input logic w, input logic f, input logic s, input int fac,
                          input logic base, input int g0, input int g1, input int g2,
                          input logic expVal, input string req);
    int p, nValid;
    setMode(w, f, s);
    rxIn = base;
    writeReg(1'b0, 8'd1);
    writeReg(1'b1, 8'd0);
    do @(negedge clk); while (!bitTick);
    p = 0; nValid = 0;
    while (p < fac) begin
      @(negedge clk);
      if (rxValid) nValid++;
      if (osTick) begin
        rxIn = (p == g0 || p == g1 || p == g2) ? !base : base;
        p++;
      end
    end
    rxIn = base;
    check(rxSample == expVal, req, "decided bit", int'(rxSample), int'(expVal));
    check(nValid == 1, "R9", "rxValid pulses per bit", nValid, 1);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int osP, bitP, nOs, nBit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6: reset state; zero divisor gives a tick every cycle
    check(osTick == 1'b1, "R6", "osTick after reset", int'(osTick), 1);
    check(rxSample == 1'b1, "R6", "rxSample after reset", int'(rxSample), 1);
    check(rxValid == 1'b0, "R6", "rxValid after reset", int'(rxValid), 0);
    check(bitTick == 1'b0, "R6", "bitTick after reset", int'(bitTick), 0);

    for (int i = 0; i < 9; i++) begin
      setMode(VECS[i].wide, VECS[i].fast, VECS[i].sync);
      writeReg(1'b0, VECS[i].lo);
      writeReg(1'b1, VECS[i].hi);
      measure(osP, bitP);
      check(osP == VECS[i].expOs, VECS[i].wide ? "R2" : "R1", "osTick period", osP, VECS[i].expOs);
      check(bitP == VECS[i].expBit, "R3", "bitTick period", bitP, VECS[i].expBit);
    end

    restartCheck(1'b0, 8'd100);
    restartCheck(1'b1, 8'd0);

    // R5: zero divisor in the fastest mode
    setMode(1'b1, 1'b1, 1'b0);
    writeReg(1'b0, 8'd0);
    writeReg(1'b1, 8'd0);
    nOs = 0; nBit = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (osTick) nOs++;
      if (bitTick) nBit++;
    end
    check(nOs == 20, "R5", "osTick count in 20 cycles", nOs, 20);
    check(nBit == 5, "R5", "bitTick count in 20 cycles", nBit, 5);

    // R7: vote on ticks m-1, m, m+1
    bitCheck(1'b0, 1'b1, 1'b0, 16, 1'b0, 8, -1, -1, 1'b0, "R7");
    bitCheck(1'b0, 1'b1, 1'b0, 16, 1'b0, 7, 9, -1, 1'b1, "R7");
    bitCheck(1'b0, 1'b0, 1'b0, 64, 1'b1, 32, 33, -1, 1'b0, "R7");
    bitCheck(1'b1, 1'b0, 1'b0, 16, 1'b1, 6, 10, -1, 1'b1, "R7");
    // R8: single read on tick m
    bitCheck(1'b0, 1'b0, 1'b1, 4, 1'b0, 2, -1, -1, 1'b1, "R8");
    bitCheck(1'b1, 1'b1, 1'b0, 4, 1'b1, 1, 3, -1, 1'b1, "R8");
    bitCheck(1'b1, 1'b1, 1'b1, 4, 1'b0, 2, -1, -1, 1'b1, "R8");
    bitCheck(1'b1, 1'b1, 1'b0, 4, 1'b0, 2, -1, -1, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule